// File: doc/BRIEF.md
# Keyed System Error Interrupt Aggregator

This block gathers single-cycle error event strobes from eight sources into a sticky flag register and turns the first pending error into one interrupt pulse. A global gate flag is raised along with the pulse. While the gate flag is up, further errors are still recorded, but no new pulse is issued until software clears the gate.

Software reaches the block over a simple 32-bit register bus with byte enables and combinational read data. The bus exposes four words: a read-only flag view, a write-one-to-clear port, a write-one-to-set port and a per-source mask. The set and mask ports are guarded twice. The write must be a full-width write carrying the byte 0xA5 in bits 31:24, and the privileged-write enable input must be high during that write. The flag and clear ports are not guarded.

Top module: `syserr_aggregator`

## Requirements
- R1: After reset, every register reads zero and `irq_out` is low.
- R2: Only the flag positions 2, 4, 10, 11, 16, 17, 18, 19 and the gate flag at bit 0 can ever read as one. Every other bit of every register reads zero. Source k (k = 0..7) drives the flag positions 2, 4, 10, 11, 16, 17, 18, 19 in that order.
- R3: A source strobe sampled at a clock edge sets its flag at that edge, provided its mask bit is zero. The flag stays set after the strobe ends.
- R4: A mask bit of one stops its source from setting the matching flag.
- R5: When any flag is set and the gate flag is zero, `irq_out` is high for exactly one cycle, starting one edge after the flag became visible. The gate flag (bit 0) becomes one at that same edge.
- R6: While the gate flag is one, no further pulse is issued, even when new flags are set.
- R7: A write to the clear word (offset 0x12) clears every flag whose data bit is one, in the byte lanes that are enabled. Bit 0 clears the gate flag. The clear word always reads zero.
- R8: A write to the set word (offset 0x14) forces to one every live error flag whose data bit is one, whatever the mask holds, and the result raises a pulse like a hardware event. Bit 0 cannot be forced. The set word reads zero.
- R9: A write to the set or mask word takes effect only if bits 31:24 of the same write equal 0xA5.
- R10: A write to the set or mask word whose byte enables are not all four ones is ignored.
- R11: The set and mask words also require `priv_en` to be high during the write. Clear writes work with `priv_en` low.
- R12: If a source strobe and a clear of the same flag arrive in the same cycle, the flag stays set.
- R13: When the gate flag is cleared while error flags are still set, a new pulse follows one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_event | input | 8 | Single-cycle error strobes, one per source |
| priv_en | input | 1 | Privileged-write enable for the set and mask words |
| bus_addr | input | 8 | Word offset of the register access |
| bus_wr | input | 1 | Write strobe |
| bus_be | input | 4 | Byte enables of the write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| irq_out | output | 1 | One-cycle interrupt pulse |

## Verification
Some properties hold on every cycle, and the assertions check them there. The pulse is never longer than one cycle and appears only together with a fresh rise of the gate flag. Reserved bits always read zero, and so does the clear word. An unprivileged write to the mask never changes it, and an unmasked strobe always leaves its flag set. Other behaviour needs a chosen sequence of writes and events, so only the bench scenarios show it. That covers the key check, the rejection of partial writes, clear and set acting on chosen bits, the event winning over a same-cycle clear, the pulse being held back while the gate is up, and the pulse being reissued once the gate is cleared.

// File: rtl/syserr_aggregator.sv
module syserr_aggregator #(
  parameter int          ADDR_W    = 8,
  parameter logic [7:0]  KEY_VAL   = 8'hA5,
  parameter logic [31:0] LIVE_BITS = 32'h000F_0C15,
  parameter logic [7:0]  FLAG_OFS  = 8'h10,
  parameter logic [7:0]  CLR_OFS   = 8'h12,
  parameter logic [7:0]  SET_OFS   = 8'h14,
  parameter logic [7:0]  MASK_OFS  = 8'h16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        src_event,
  input  logic              priv_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [3:0]        bus_be,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq_out
);
  localparam logic [31:0] ERR_BITS = LIVE_BITS & ~32'h1;

  logic [31:0] flag_q, mask_q;
  logic        irq_q;

  logic [31:0] evt_vec, lane_bits, clr_vec, set_vec, hw_vec, err_d;
  logic        guard_ok, fire, gate_d;

  assign evt_vec   = {12'b0, src_event[7:4], 4'b0, src_event[3:2], 5'b0,
                      src_event[1], 1'b0, src_event[0], 2'b0};
  assign lane_bits = {{8{bus_be[3]}}, {8{bus_be[2]}}, {8{bus_be[1]}}, {8{bus_be[0]}}};

  assign guard_ok = bus_wr && (bus_be == 4'hF) && (bus_wdata[31:24] == KEY_VAL) && priv_en;

  assign clr_vec = (bus_wr && bus_addr == ADDR_W'(CLR_OFS)) ? (bus_wdata & lane_bits & LIVE_BITS) : '0;
  assign set_vec = (guard_ok && bus_addr == ADDR_W'(SET_OFS)) ? (bus_wdata & ERR_BITS) : '0;
  assign hw_vec  = evt_vec & ~mask_q & ERR_BITS;
  assign err_d   = (flag_q & ERR_BITS & ~clr_vec) | hw_vec | set_vec;

  assign fire   = (|(flag_q & ERR_BITS)) && !flag_q[0];
  assign gate_d = fire ? 1'b1 : (clr_vec[0] ? 1'b0 : flag_q[0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q <= '0;
      mask_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      flag_q <= err_d | {31'b0, gate_d};
      irq_q  <= fire;
      if (guard_ok && bus_addr == ADDR_W'(MASK_OFS))
        mask_q <= bus_wdata & ERR_BITS;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(FLAG_OFS))      bus_rdata = flag_q;
    else if (bus_addr == ADDR_W'(MASK_OFS)) bus_rdata = mask_q;
  end

  assign irq_out = irq_q;
endmodule

module syserr_aggregator_chk #(
  parameter int          ADDR_W    = 8,
  parameter logic [31:0] LIVE_BITS = 32'h000F_0C15,
  parameter logic [7:0]  CLR_OFS   = 8'h12,
  parameter logic [7:0]  MASK_OFS  = 8'h16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [7:0]        src_event,
  input logic              priv_en,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [31:0]       bus_rdata,
  input logic              irq_out,
  input logic [31:0]       flag_q,
  input logic [31:0]       mask_q
);
  logic [31:0] strobe_pos;
  assign strobe_pos = {12'b0, src_event[7:4], 4'b0, src_event[3:2], 5'b0,
                       src_event[1], 1'b0, src_event[0], 2'b0} & ~mask_q;

  // R5
  irq_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |=> !irq_out);

  // R6
  irq_gate_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (flag_q[0] && !$past(flag_q[0])));

  // R2
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rdata & ~LIVE_BITS) == 32'h0);

  // R7
  clr_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'(CLR_OFS)) |-> (bus_rdata == 32'h0));

  // R11
  mask_priv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(MASK_OFS) && !priv_en) |=> $stable(mask_q));

  // R3
  evt_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_pos != 32'h0) |=> ((flag_q & $past(strobe_pos)) == $past(strobe_pos)));
endmodule

bind syserr_aggregator syserr_aggregator_chk #(
  .ADDR_W(ADDR_W), .LIVE_BITS(LIVE_BITS), .CLR_OFS(CLR_OFS), .MASK_OFS(MASK_OFS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .src_event(src_event), .priv_en(priv_en),
  .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rdata(bus_rdata),
  .irq_out(irq_out), .flag_q(flag_q), .mask_q(mask_q)
);

// File: tb/syserr_aggregator_bench.sv
module syserr_aggregator_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] A_FLG = 8'h10, A_CLR = 8'h12, A_SET = 8'h14, A_MSK = 8'h16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  src_event = '0;
  logic        priv_en = 1'b0;
  logic [7:0]  bus_addr = A_FLG;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_out;

  int n_cmp = 0;
  int n_bad = 0;

  syserr_aggregator u_syserr_aggregator (
    .clk(clk), .rst_n(rst_n), .src_event(src_event), .priv_en(priv_en),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_be(bus_be),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // mask-write vectors: {priv, be, wdata} and the mask expected afterwards
  localparam logic [36:0] MVEC [0:6] = '{
    {1'b1, 4'hF, 32'hA50F_FFFF},
    {1'b1, 4'hF, 32'h5A00_0000},
    {1'b1, 4'hF, 32'hA500_0004},
    {1'b0, 4'hF, 32'hA500_0010},
    {1'b1, 4'h7, 32'hA500_0010},
    {1'b1, 4'hE, 32'hA500_0010},
    {1'b1, 4'hF, 32'hA500_0000}
  };
  localparam logic [31:0] MEXP [0:6] = '{
    32'h000F_0C14, 32'h000F_0C14, 32'h0000_0004, 32'h0000_0004,
    32'h0000_0004, 32'h0000_0004, 32'h0000_0000
  };
  localparam string MREQ [0:6] = '{"R2", "R9", "R9", "R11", "R10", "R10", "R9"};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d, input logic p);
    bus_addr = a; bus_be = be; bus_wdata = d; priv_en = p; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_be = '0; priv_en = 1'b0; bus_addr = A_FLG;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    bus_addr = a;
    #1;
    v = bus_rdata;
    bus_addr = A_FLG;
  endtask

  task automatic pulse_src(input logic [7:0] m);
    src_event = m;
    @(negedge clk);
    src_event = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(A_FLG, v); check("R1 flags", v, 32'h0);
    rd(A_MSK, v); check("R1 mask", v, 32'h0);
    rd(A_SET, v); check("R1 set", v, 32'h0);
    check("R1 irq", {31'b0, irq_out}, 32'h0);

    // table walk over guarded mask writes
    for (int i = 0; i < 7; i++) begin
      wr(A_MSK, MVEC[i][35:32], MVEC[i][31:0], MVEC[i][36]);
      rd(A_MSK, v);
      check(MREQ[i], v, MEXP[i]);
    end
    rd(A_FLG, v); check("R2 flags idle", v, 32'h0);

    // R3 / R5: source 0 -> bit 2, pulse one edge later
    pulse_src(8'h01);
    rd(A_FLG, v); check("R3 flag set", v, 32'h0000_0004);
    check("R5 no irq yet", {31'b0, irq_out}, 32'h0);
    @(negedge clk);
    check("R5 irq high", {31'b0, irq_out}, 32'h1);
    rd(A_FLG, v); check("R5 gate set", v, 32'h0000_0005);
    @(negedge clk);
    check("R5 irq one cycle", {31'b0, irq_out}, 32'h0);

    // R6: source 7 -> bit 19 while gate is up
    pulse_src(8'h80);
    rd(A_FLG, v); check("R6 flag recorded", v, 32'h0008_0005);
    for (int i = 0; i < 3; i++) begin
      check("R6 no pulse", {31'b0, irq_out}, 32'h0);
      @(negedge clk);
    end

    // R7 / R11: clear without privilege
    wr(A_CLR, 4'hF, 32'h0008_0004, 1'b0);
    rd(A_FLG, v); check("R7 clear errs", v, 32'h0000_0001);
    rd(A_CLR, v); check("R7 clear reads zero", v, 32'h0);
    wr(A_CLR, 4'hF, 32'h0000_0001, 1'b0);
    rd(A_FLG, v); check("R11 clear gate unprivileged", v, 32'h0);
    @(negedge clk);
    check("R7 no pulse after clear", {31'b0, irq_out}, 32'h0);

    // R4: mask source 1 (bit 4)
    wr(A_MSK, 4'hF, 32'hA500_0010, 1'b1);
    pulse_src(8'h02);
    rd(A_FLG, v); check("R4 masked event", v, 32'h0);
    @(negedge clk);
    check("R4 no pulse", {31'b0, irq_out}, 32'h0);

    // R8: forced flag despite mask
    wr(A_SET, 4'hF, 32'hA500_0010, 1'b1);
    rd(A_FLG, v); check("R8 forced flag", v, 32'h0000_0010);
    @(negedge clk);
    check("R8 pulse from set", {31'b0, irq_out}, 32'h1);
    rd(A_SET, v); check("R8 set reads zero", v, 32'h0);
    wr(A_CLR, 4'hF, 32'h0000_0011, 1'b0);
    rd(A_FLG, v); check("R7 clear all", v, 32'h0);
    wr(A_SET, 4'hF, 32'hA500_0001, 1'b1);
    rd(A_FLG, v); check("R8 gate not forceable", v, 32'h0);
    @(negedge clk);
    check("R8 no pulse", {31'b0, irq_out}, 32'h0);
    wr(A_SET, 4'hF, 32'h0000_0800, 1'b1);
    rd(A_FLG, v); check("R9 set bad key", v, 32'h0);
    wr(A_SET, 4'hF, 32'hA500_0800, 1'b0);
    rd(A_FLG, v); check("R11 set unprivileged", v, 32'h0);
    wr(A_SET, 4'h7, 32'hA500_0800, 1'b1);
    rd(A_FLG, v); check("R10 set partial", v, 32'h0);
    wr(A_MSK, 4'hF, 32'hA500_0000, 1'b1);

    // R12: source 2 -> bit 10, event beats clear
    pulse_src(8'h04);
    @(negedge clk);
    rd(A_FLG, v); check("R3 bit10 and gate", v, 32'h0000_0401);
    src_event = 8'h04;
    wr(A_CLR, 4'hF, 32'h0000_0400, 1'b0);
    src_event = '0;
    rd(A_FLG, v); check("R12 event wins", v, 32'h0000_0401);
    wr(A_CLR, 4'h1, 32'h0000_0400, 1'b0);
    rd(A_FLG, v); check("R7 disabled lane", v, 32'h0000_0401);

    // R13: gate cleared with flag pending
    wr(A_CLR, 4'hF, 32'h0000_0001, 1'b0);
    rd(A_FLG, v); check("R13 gate cleared", v, 32'h0000_0400);
    @(negedge clk);
    check("R13 pulse reissued", {31'b0, irq_out}, 32'h1);
    rd(A_FLG, v); check("R13 gate set again", v, 32'h0000_0401);
    wr(A_CLR, 4'hF, 32'h0000_0401, 1'b0);
    rd(A_FLG, v); check("R7 final clear", v, 32'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule